// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal sync, vertical sync and data-enable strobes for a raster display, together with the pixel column and row being scanned, a one-cycle start-of-frame marker and a maskable vertical-sync interrupt. Software sets the length of every horizontal and vertical interval through a plain register write port, picks the active level of each strobe, and starts or stops the scan with a command bit. Every interval register holds the interval length minus one.

Each line is scanned as sync, back porch, active, front porch, in that order. A frame walks through its lines in the same order. All timing and polarity registers are written into a staging copy. The counters only read a shadow copy. The shadow copy follows the staging copy while the scan is stopped, and is reloaded from it only at the edge where one frame ends and the next begins. Software can therefore reprogram a running display without tearing a frame.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset the scan is stopped, the polarity word is 3'b100, hsync and vsync sit high (inactive), de is low, pix_x and pix_y are 0, sof and irq are low.
- R2: While running, a line lasts (hsync+1)+(hback+1)+(hactive+1)+(hfront+1) cycles, ordered sync, back porch, active, front porch. The sync strobe is active for exactly hsync+1 cycles at the start of each line. Lengths are at addresses 1..4 in that order.
- R3: A frame lasts (vsync+1)+(vback+1)+(vactive+1)+(vfront+1) lines in the same order. vsync is active for the whole of the first vsync+1 lines. Lengths are at addresses 5..8 in that order.
- R4: de is active only when both axes are in their active interval. pix_x counts 0..hactive across the active pixels of a line and pix_y counts 0..vactive across the active lines. Both read 0 outside the active area.
- R5: Polarity word at address 9: bit 0 set makes hsync active-high, bit 1 set makes vsync active-high, bit 2 set makes de active-high. A clear bit means active-low.
- R6: Writing 1 to bit 0 of address 0 starts the scan; the first cycle after that write is cycle 0 of a frame. Writing 0 stops it: from the next cycle the position reads 0, de and both syncs are at their inactive level, and sof stays low, even mid-frame.
- R7: sof is high for exactly one cycle, the first cycle of every frame.
- R8: The status bit is set in the cycle after sof. It is cleared by writing 1 to bit 0 of address 11, and set wins over clear. irq equals status AND the mask bit (bit 0 of address 10), and the mask takes effect immediately.
- R9: Length and polarity writes made while running leave the current frame unchanged and take effect from the first cycle of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (4) | Register address |
| wr_data | input | DW (32) | Register write data |
| hsync | output | 1 | Horizontal sync, level set by polarity bit 0 |
| vsync | output | 1 | Vertical sync, level set by polarity bit 1 |
| de | output | 1 | Data enable, level set by polarity bit 2 |
| pix_x | output | CW (12) | Column within the active line |
| pix_y | output | CW (12) | Row within the active frame |
| sof | output | 1 | One-cycle start-of-frame marker |
| irq | output | 1 | Vertical-sync interrupt, status AND mask |

## Verification
A write is captured at a clock edge. Start, stop, mask and status-clear writes show up on the outputs in the cycle right after that edge. A polarity write made while stopped needs one more cycle, because it passes through the shadow copy. The status bit, and so irq, follows sof by one cycle. A length write made mid-frame shows up only at the next frame's cycle 0.

The driver pushes the expected outputs for each cycle right after the clock edge that starts that cycle. The monitor pops and compares one item on each falling edge. A stop write is issued in the same instant the monitor pops the last expected running cycle, so the stopped items line up with the cycle after the stop edge.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

   // interval order inside a line and inside a frame; the value is also the
   // offset of that interval's length register from the axis base address
   typedef enum logic [1:0] {
      PH_SYNC  = 2'd0,
      PH_BACK  = 2'd1,
      PH_ACT   = 2'd2,
      PH_FRONT = 2'd3
   } phase_e;

   localparam int N_SEG  = 4;
   localparam int N_AXIS = 2;

   // register addresses
   localparam int A_RUN  = 0;
   localparam int A_HSEG = 1;   // 1..4 : horizontal intervals, minus one
   localparam int A_VSEG = 5;   // 5..8 : vertical intervals, minus one
   localparam int A_POL  = 9;
   localparam int A_MASK = 10;
   localparam int A_STAT = 11;
   localparam int A_LAST = A_STAT;

   // polarity word bits, set = active-high
   localparam int POL_W  = 3;
   localparam int POL_HS = 0;
   localparam int POL_VS = 1;
   localparam int POL_DE = 2;
   localparam logic [POL_W-1:0] POL_RST = 3'b100;

endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
   import rtg_pkg::*;
#(
   parameter int CW = 12,
   parameter int AW = 4,
   parameter int DW = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [AW-1:0]              wr_addr,
   input  logic [DW-1:0]              wr_data,
   input  logic                       frame_wrap,
   input  logic                       irq_set,
   output logic                       run,
   output logic [N_SEG-1:0][CW-1:0]   h_len,
   output logic [N_SEG-1:0][CW-1:0]   v_len,
   output logic [POL_W-1:0]           pol,
   output logic                       mask,
   output logic                       status
);

   logic [N_SEG-1:0][CW-1:0] stg_h;
   logic [N_SEG-1:0][CW-1:0] stg_v;
   logic [POL_W-1:0]         stg_pol;
   logic                     clr_hit;

   assign clr_hit = wr_en && (wr_addr == AW'(A_STAT)) && wr_data[0];

   // staging copy and directly acting control bits
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_h   <= '0;
         stg_v   <= '0;
         stg_pol <= POL_RST;
         run     <= 1'b0;
         mask    <= 1'b0;
      end else if (wr_en) begin
         if (wr_addr == AW'(A_RUN))  run     <= wr_data[0];
         if (wr_addr == AW'(A_MASK)) mask    <= wr_data[0];
         if (wr_addr == AW'(A_POL))  stg_pol <= wr_data[POL_W-1:0];
         for (int i = 0; i < N_SEG; i++) begin
            if (wr_addr == AW'(A_HSEG + i)) stg_h[i] <= wr_data[CW-1:0];
            if (wr_addr == AW'(A_VSEG + i)) stg_v[i] <= wr_data[CW-1:0];
         end
      end
   end

   // shadow copy seen by the counters: tracks staging while stopped,
   // reloads only on the frame boundary while running
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_len <= '0;
         v_len <= '0;
         pol   <= POL_RST;
      end else if (!run || frame_wrap) begin
         h_len <= stg_h;
         v_len <= stg_v;
         pol   <= stg_pol;
      end
   end

   // interrupt status, set has priority over the write-one clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        status <= 1'b0;
      else if (irq_set)  status <= 1'b1;
      else if (clr_hit)  status <= 1'b0;
   end

   // R9: mid-frame the timing seen by the counters does not move
   assert_shadow_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && !$past(frame_wrap)) |->
         ($stable(h_len) && $stable(v_len) && $stable(pol)));

endmodule

// File: rtl/rtg_axis.sv
module rtg_axis
   import rtg_pkg::*;
#(
   parameter int CW = 12
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr,
   input  logic                     adv,
   input  logic [N_SEG-1:0][CW-1:0] len,
   output phase_e                   phase,
   output logic [CW-1:0]            cnt,
   output logic                     wrap
);

   logic seg_done;

   assign seg_done = (cnt == len[phase]);
   assign wrap     = (phase == PH_FRONT) && seg_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_SYNC;
         cnt   <= '0;
      end else if (clr) begin
         phase <= PH_SYNC;
         cnt   <= '0;
      end else if (adv) begin
         if (seg_done) begin
            cnt   <= '0;
            phase <= phase_e'(phase + 2'd1);
         end else begin
            cnt   <= cnt + 1'b1;
         end
      end
   end

   // R2/R3: the interval counter never runs past the programmed length
   assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |-> (cnt <= len[phase]));

   // R6: a stop leaves the axis at the start of its sync interval
   assert_stop_home_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clr) |=> (phase == PH_SYNC && cnt == '0));

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
   import rtg_pkg::*;
#(
   parameter int CW = 12,
   parameter int AW = 4,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   output logic          hsync,
   output logic          vsync,
   output logic          de,
   output logic [CW-1:0] pix_x,
   output logic [CW-1:0] pix_y,
   output logic          sof,
   output logic          irq
);

   localparam int AXIS_H = 0;
   localparam int AXIS_V = 1;

   // elaboration-time parameter checks
   if (CW < 2) begin : g_bad_cw
      initial $fatal(1, "CW must be at least 2");
   end
   if (DW < CW || DW < POL_W) begin : g_bad_dw
      initial $fatal(1, "DW too narrow for the length fields");
   end
   if ((1 << AW) <= A_LAST) begin : g_bad_aw
      initial $fatal(1, "AW too narrow for the register map");
   end

   logic                     run;
   logic                     mask;
   logic                     status;
   logic [POL_W-1:0]         pol;
   logic [N_SEG-1:0][CW-1:0] h_len;
   logic [N_SEG-1:0][CW-1:0] v_len;
   logic [N_SEG-1:0][CW-1:0] seg_len [N_AXIS];
   phase_e                   ph      [N_AXIS];
   logic [CW-1:0]            cnt     [N_AXIS];
   logic [N_AXIS-1:0]        wrap;
   logic [N_AXIS-1:0]        adv;
   logic                     frame_wrap;
   logic                     hs_act;
   logic                     vs_act;
   logic                     de_act;
   logic                     h_in_act;
   logic                     v_in_act;

   rtg_regs #(.CW(CW), .AW(AW), .DW(DW)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .frame_wrap (frame_wrap),
      .irq_set    (sof),
      .run        (run),
      .h_len      (h_len),
      .v_len      (v_len),
      .pol        (pol),
      .mask       (mask),
      .status     (status)
   );

   assign seg_len[AXIS_H] = h_len;
   assign seg_len[AXIS_V] = v_len;
   assign adv[AXIS_H]     = run;
   assign adv[AXIS_V]     = run & wrap[AXIS_H];
   assign frame_wrap      = run & wrap[AXIS_H] & wrap[AXIS_V];

   for (genvar g = 0; g < N_AXIS; g++) begin : g_axis
      rtg_axis #(.CW(CW)) u_axis (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (!run),
         .adv   (adv[g]),
         .len   (seg_len[g]),
         .phase (ph[g]),
         .cnt   (cnt[g]),
         .wrap  (wrap[g])
      );
   end

   assign h_in_act = run && (ph[AXIS_H] == PH_ACT);
   assign v_in_act = run && (ph[AXIS_V] == PH_ACT);
   assign hs_act   = run && (ph[AXIS_H] == PH_SYNC);
   assign vs_act   = run && (ph[AXIS_V] == PH_SYNC);
   assign de_act   = h_in_act && v_in_act;

   assign pix_x = h_in_act ? cnt[AXIS_H] : '0;
   assign pix_y = v_in_act ? cnt[AXIS_V] : '0;
   assign sof   = hs_act && vs_act && (cnt[AXIS_H] == '0) && (cnt[AXIS_V] == '0);

   assign hsync = pol[POL_HS] ? hs_act : !hs_act;
   assign vsync = pol[POL_VS] ? vs_act : !vs_act;
   assign de    = pol[POL_DE] ? de_act : !de_act;
   assign irq   = status & mask;

   // R8: every frame start leaves the status bit set
   assert_status_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sof |=> status);

   // R4: the reported position stays inside the programmed active area
   assert_pos_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      de_act |-> (pix_x <= h_len[PH_ACT] && pix_y <= v_len[PH_ACT]));

   // R3: vertical sync only changes on a line boundary while scanning
   assert_vs_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && !$stable(vs_act)) |->
         (ph[AXIS_H] == PH_SYNC && cnt[AXIS_H] == '0));

   // R7: start of frame is a single-cycle marker
   assert_sof_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sof |=> !sof);

endmodule

// File: tb/sim_raster_timing_gen.sv
`timescale 1ns/1ps
module sim_raster_timing_gen;
   import rtg_pkg::*;

   localparam int CW = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        hsync, vsync, de, sof, irq;
   logic [CW-1:0] pix_x, pix_y;

   always #2 clk = ~clk;   // 250 MHz

   raster_timing_gen u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .hsync(hsync), .vsync(vsync), .de(de), .pix_x(pix_x), .pix_y(pix_y),
      .sof(sof), .irq(irq));

   typedef struct {
      bit    hs;
      bit    vs;
      bit    de;
      int    x;
      int    y;
      bit    sof;
      bit    irq;
      string tag;
   } exp_t;

   exp_t     q[$];
   int       total = 0;
   int       bad = 0;
   int       c_h[4];
   int       c_v[4];
   bit [2:0] c_pol = 3'b100;
   bit       m_st = 1'b0;
   bit       m_mask = 1'b0;

   task automatic chk(bit ok, string req, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int sum4(int a[4]);
      return a[0] + a[1] + a[2] + a[3];
   endfunction

   function automatic int flen();
      return sum4(c_h) * sum4(c_v);
   endfunction

   // expected outputs for cycle t of a frame, from the interval counts
   function automatic exp_t model(int t, string tag);
      exp_t e;
      int   ll = sum4(c_h);
      int   ln = t / ll;
      int   p  = t % ll;
      bit   ha = (p >= c_h[0] + c_h[1]) && (p < c_h[0] + c_h[1] + c_h[2]);
      bit   va = (ln >= c_v[0] + c_v[1]) && (ln < c_v[0] + c_v[1] + c_v[2]);
      bit   hs = (p < c_h[0]);
      bit   vs = (ln < c_v[0]);
      e.hs  = c_pol[0] ? hs : !hs;
      e.vs  = c_pol[1] ? vs : !vs;
      e.de  = c_pol[2] ? (ha && va) : !(ha && va);
      e.x   = ha ? p - c_h[0] - c_h[1] : 0;
      e.y   = va ? ln - c_v[0] - c_v[1] : 0;
      e.sof = (t == 0);
      e.irq = 1'b0;
      e.tag = tag;
      return e;
   endfunction

   task automatic push_frame(int ncyc, string tag);
      for (int t = 0; t < ncyc; t++) begin
         exp_t e = model(t, tag);
         e.irq = m_st && m_mask;
         q.push_back(e);
         if (e.sof) m_st = 1'b1;
      end
   endtask

   task automatic push_idle(int n, string tag);
      for (int i = 0; i < n; i++) begin
         exp_t e;
         e.hs  = !c_pol[0];
         e.vs  = !c_pol[1];
         e.de  = !c_pol[2];
         e.x   = 0;
         e.y   = 0;
         e.sof = 1'b0;
         e.irq = m_st && m_mask;
         e.tag = tag;
         q.push_back(e);
      end
   endtask

   // sync=1 waits for a falling edge; sync=0 drives in the current instant
   task automatic wr(bit sync, int a, int d);
      if (sync) @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = a[3:0];
      wr_data = d;
      @(posedge clk);
      #1 wr_en = 1'b0;
   endtask

   task automatic drain();
      wait (q.size() == 0);
   endtask

   task automatic program_lengths();
      for (int i = 0; i < 4; i++) begin
         wr(1, A_HSEG + i, c_h[i] - 1);
         wr(1, A_VSEG + i, c_v[i] - 1);
      end
   endtask

   // monitor: one expected item per cycle, compared on the falling edge
   initial begin
      forever begin
         @(negedge clk);
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(hsync === e.hs,  {e.tag, " hsync R2"}, int'(hsync), int'(e.hs));
            chk(vsync === e.vs,  {e.tag, " vsync R3"}, int'(vsync), int'(e.vs));
            chk(de === e.de,     {e.tag, " de R4"},    int'(de),    int'(e.de));
            chk(int'(pix_x) == e.x, {e.tag, " pix_x R4"}, int'(pix_x), e.x);
            chk(int'(pix_y) == e.y, {e.tag, " pix_y R4"}, int'(pix_y), e.y);
            chk(sof === e.sof,   {e.tag, " sof R7"},   int'(sof),   int'(e.sof));
            chk(irq === e.irq,   {e.tag, " irq R8"},   int'(irq),   int'(e.irq));
         end
      end
   end

   task automatic main_seq();
      // R1: reset state
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk);
      #1 push_idle(3, "R1 reset");
      drain();

      // configuration A, mask on
      c_h = '{2, 1, 4, 2};
      c_v = '{1, 1, 3, 2};
      program_lengths();
      wr(1, A_MASK, 1);
      m_mask = 1'b1;

      // R2 R3 R4 R7 R8: two full frames, then a stop on the frame boundary
      wr(1, A_RUN, 1);
      push_frame(flen(), "R2 R3 frame A1");
      push_frame(flen(), "R2 R3 frame A2");
      drain();
      wr(0, A_RUN, 0);
      push_idle(2, "R6 stop at boundary");
      drain();

      // R8: write-one clear of the status bit
      wr(1, A_STAT, 1);
      m_st = 1'b0;
      push_idle(1, "R8 status clear");
      drain();

      // R5: all strobes active-high, seen at the idle levels
      wr(1, A_POL, 7);
      c_pol = 3'b111;
      @(posedge clk);
      #1 push_idle(2, "R5 polarity idle");
      drain();

      // R5 R9: run with new polarity, reprogram mid-frame
      wr(1, A_RUN, 1);
      push_frame(flen(), "R5 frame high-active");
      wr(1, A_HSEG + 2, 2);
      wr(1, A_VSEG + 3, 0);
      c_h[2] = 3;
      c_v[3] = 1;
      push_frame(flen(), "R9 frame after reprogram");
      push_frame(20, "R6 partial frame");
      drain();
      wr(0, A_RUN, 0);
      push_idle(2, "R6 stop mid-frame");
      drain();

      // R8: mask off hides a pending status
      wr(1, A_MASK, 0);
      m_mask = 1'b0;
      wr(1, A_RUN, 1);
      push_frame(flen(), "R8 masked frame");
      drain();
      wr(0, A_RUN, 0);
      push_idle(1, "R6 final stop");
      drain();
      @(negedge clk);
   endtask

   initial begin
      fork
         main_seq();
         begin
            #(4 * 200000);
            bad++;
            total++;
            $display("FAIL watchdog expired, queue=%0d expected=0", q.size());
         end
      join_any
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule